// File: doc/BRIEF.md
# Grouped Interrupt Status, Disable and Acknowledge Word

This block is a single 32-bit interrupt register shared by eight event sources. Each source has one cell in each of three 8-bit fields of the same word: a sticky status flag, a disable flag and an acknowledge bit. A one-cycle pulse on a source's event input latches its status flag. Software reads the word to see which sources are pending and writes the word to change the disable flags and to acknowledge sources. The pending sources that are not disabled are merged onto one interrupt line to the processor.

Source 0 is normally wired to a camera frame event, which pulses once at the start of each new frame. The other seven sources are generic. Writes use a plain write-enable and data port. The read data always reflects the current register contents, so a read needs no strobe.

Field positions matter to software. Status sits in bits 0 to 7, disable in bits 8 to 15 and acknowledge in bits 16 to 23, with source n at offset n inside each field.

Top module: `irq_word_reg`

## Requirements
- R1: After reset, every status flag and every disable flag is 0, `rd_data` is 0 and `irq_out` is 0.
- R2: A 1 on `evt_pulse[n]` during a clock edge sets status flag n, which reads back at `rd_data` bit n from the next cycle on.
- R3: A status flag latches on its event even while its disable flag is 1.
- R4: `irq_out` is 1 exactly when some source n has status 1 and disable 0. It is computed from the registered flags, so it is valid in the cycle after the edge that changed them.
- R5: A write with data bit 16+n set clears status flag n. A write with data bit 16+n clear leaves status flag n unchanged.
- R6: When an event on source n and an acknowledge of source n meet at the same edge, status flag n is 1 afterwards.
- R7: Every write loads data bits 8 to 15 into the disable flags, and those flags read back at `rd_data` bits 8 to 15. Disable bit 8+n set to 1 masks source n.
- R8: `rd_data` bits 16 to 31 always read 0. Written values in data bits 0 to 7 and 24 to 31 change nothing.
- R9: Without an acknowledge for it, a status flag that is 1 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | 8 | One event pulse input per source |
| wr_en | input | 1 | Register write strobe for one cycle |
| wr_data | input | 32 | Write data: disable field and acknowledge field |
| rd_data | output | 32 | Current register word |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Single pulses on one source show that each flag latches and holds on its own. A pulse on a disabled source separates latching from output gating. Acknowledge writes are tried with the acknowledge bit set and with it clear, and one acknowledge lands on the same edge as a fresh event to show which of the two wins. A write of all ones to the status and upper bytes shows that those bits are ignored. A long random mix of events, mask writes and acknowledges is then compared cycle by cycle against a behavioural model. That mix finds any cross-talk between sources that the directed cases miss.

// File: rtl/irqw_pkg.sv
package irqw_pkg;
  localparam int IRQW_NSRC   = 8;
  localparam int IRQW_WORD_W = 32;

  // field order inside the word; software decodes these positions
  typedef enum int {FLD_STATUS = 0, FLD_DISABLE = 1, FLD_ACK = 2} irqw_field_e;

  function automatic int field_lo(irqw_field_e f, int nsrc);
    return int'(f) * nsrc;
  endfunction
endpackage

// File: rtl/irqw_status_bank.sv
module irqw_status_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] clr_taken
);
  // set beats clear on the same edge (R6)
  function automatic logic next_flag(logic cur, logic s, logic c);
    if (s)      return 1'b1;
    else if (c) return 1'b0;
    else        return cur;
  endfunction

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= next_flag(status_q[i], set_vec[i], clr_vec[i]);
    end
    assign clr_taken[i] = clr_vec[i] & ~set_vec[i];
  end
endmodule

// File: rtl/irqw_mask_reg.sv
module irqw_mask_reg #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NSRC-1:0] load_val,
  output logic [NSRC-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= '0;
    else if (load) mask_q <= load_val;
  end
endmodule

// File: rtl/irqw_irq_merge.sv
module irqw_irq_merge #(
  parameter int NSRC = 8
) (
  input  logic [NSRC-1:0] status_q,
  input  logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] pend_vec,
  output logic            irq
);
  function automatic logic [NSRC-1:0] gate(logic [NSRC-1:0] st, logic [NSRC-1:0] dis);
    return st & ~dis;
  endfunction

  assign pend_vec = gate(status_q, mask_q);
  assign irq      = |pend_vec;
endmodule

// File: rtl/irq_word_reg.sv
module irq_word_reg #(
  parameter int NSRC   = irqw_pkg::IRQW_NSRC,
  parameter int WORD_W = irqw_pkg::IRQW_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_pulse,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq_out
);
  import irqw_pkg::*;

  localparam int ST_LO  = field_lo(FLD_STATUS, NSRC);
  localparam int DIS_LO = field_lo(FLD_DISABLE, NSRC);
  localparam int ACK_LO = field_lo(FLD_ACK, NSRC);
  localparam int TOP_LO = ACK_LO + NSRC;

  // named internal events, used by the checker
  logic [NSRC-1:0] ack_vec;
  logic [NSRC-1:0] clr_taken;
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend_vec;

  assign ack_vec = wr_en ? wr_data[ACK_LO +: NSRC] : '0;

  // status field and upper byte are not writable
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[ST_LO +: NSRC], wr_data[WORD_W-1:TOP_LO]};

  irqw_status_bank #(.NSRC(NSRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (evt_pulse),
    .clr_vec  (ack_vec),
    .status_q (status_q),
    .clr_taken(clr_taken)
  );

  irqw_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (wr_en),
    .load_val(wr_data[DIS_LO +: NSRC]),
    .mask_q  (mask_q)
  );

  irqw_irq_merge #(.NSRC(NSRC)) u_merge (
    .status_q(status_q),
    .mask_q  (mask_q),
    .pend_vec(pend_vec),
    .irq     (irq_out)
  );

  always_comb begin
    rd_data = '0;
    rd_data[ST_LO +: NSRC]  = status_q;
    rd_data[DIS_LO +: NSRC] = mask_q;
  end
endmodule

// File: rtl/irq_word_reg_chk.sv
module irq_word_reg_chk #(
  parameter int NSRC   = 8,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   evt_pulse,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic              irq_out,
  input logic [NSRC-1:0]   ack_vec,
  input logic [NSRC-1:0]   clr_taken,
  input logic [NSRC-1:0]   pend_vec
);
  localparam int ACK_LO = 2 * NSRC;

  // R2 / R3: every pulsed source reads 1 next cycle, whatever its disable flag
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((rd_data[NSRC-1:0] & $past(evt_pulse)) == $past(evt_pulse)));

  // R4: the line rises only with an enabled pending source
  assert_irq_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((rd_data[NSRC-1:0] & ~rd_data[2*NSRC-1:NSRC]) != '0));

  assert_irq_none_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data[NSRC-1:0] & ~rd_data[2*NSRC-1:NSRC]) != '0) |-> irq_out);

  // R5: an acknowledged source without a new event reads 0 next cycle
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_taken) |=> ((rd_data[NSRC-1:0] & $past(clr_taken)) == '0));

  // R6: the acknowledge strobe never drops a bit pulsed at the same edge
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_vec & evt_pulse)) |=> ((rd_data[NSRC-1:0] & $past(ack_vec & evt_pulse)) != '0));

  // R7: the disable field reads back what was written
  assert_mask_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[2*NSRC-1:NSRC] == $past(wr_data[2*NSRC-1:NSRC])));

  // R8: upper half reads 0
  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[WORD_W-1:ACK_LO] == '0);

  // R9: flags that are 1 stay 1 when no acknowledge comes
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec == '0) |=> ((rd_data[NSRC-1:0] & $past(rd_data[NSRC-1:0])) == $past(rd_data[NSRC-1:0])));

  // R4: pending vector is never wider than the status field
  assert_pend_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_vec & ~rd_data[NSRC-1:0]) == '0));
endmodule

bind irq_word_reg irq_word_reg_chk #(.NSRC(NSRC), .WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt_pulse(evt_pulse),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .irq_out  (irq_out),
  .ack_vec  (ack_vec),
  .clr_taken(clr_taken),
  .pend_vec (pend_vec)
);

// File: tb/test_irq_word_reg.sv
`timescale 1ns/1ps
module test_irq_word_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt_pulse = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_word_reg i_irq_word_reg (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq_out(irq_out)
  );

  // behavioural reference: plain integers per source
  int m_st[8];
  int m_dis[8];

  always @(posedge clk) begin
    for (int n = 0; n < 8; n++) begin
      if (!rst_n) begin
        m_st[n]  = 0;
        m_dis[n] = 0;
      end else begin
        if (wr_en) begin
          m_dis[n] = wr_data[8+n];
          if (wr_data[16+n]) m_st[n] = 0;
        end
        if (evt_pulse[n]) m_st[n] = 1;
      end
    end
  end

  function automatic logic [31:0] model_word();
    logic [31:0] w = 0;
    for (int n = 0; n < 8; n++) begin
      w[n]   = (m_st[n] != 0);
      w[8+n] = (m_dis[n] != 0);
    end
    return w;
  endfunction

  function automatic logic model_irq();
    int cnt = 0;
    for (int n = 0; n < 8; n++) if (m_st[n] != 0 && m_dis[n] == 0) cnt++;
    return cnt > 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R2 R4 R5 R7 R8 R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2/R5/R7/R8 word vs model", rd_data, model_word());
      check("R4 irq vs model", {31'd0, irq_out}, {31'd0, model_irq()});
    end
  end

  task automatic cyc(logic [7:0] evt, logic we, logic [31:0] d);
    evt_pulse = evt;
    wr_en     = we;
    wr_data   = d;
    @(negedge clk);
    #1;
    evt_pulse = '0;
    wr_en     = 1'b0;
    wr_data   = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    check("R1 word after reset", rd_data, 32'h0);
    check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 word after release", rd_data, 32'h0);

    // R2 / R4: single pulse on source 0
    cyc(8'h01, 1'b0, 32'h0);
    check("R2 status bit 0 set", rd_data, 32'h0000_0001);
    check("R4 irq raised", {31'd0, irq_out}, 32'd1);

    // R9: held without acknowledge
    repeat (3) cyc(8'h00, 1'b0, 32'h0);
    check("R9 status bit 0 held", rd_data, 32'h0000_0001);

    // R5: write with acknowledge bits all 0 changes nothing
    cyc(8'h00, 1'b1, 32'h0000_0000);
    check("R5 zero ack no effect", rd_data, 32'h0000_0001);

    // R7 / R4: disable source 0 masks the line
    cyc(8'h00, 1'b1, 32'h0000_0100);
    check("R7 disable readback", rd_data, 32'h0000_0101);
    check("R4 masked irq low", {31'd0, irq_out}, 32'd0);

    // R5: acknowledge source 0
    cyc(8'h00, 1'b1, 32'h0001_0100);
    check("R5 ack clears bit 0", rd_data, 32'h0000_0100);

    // R3: event on disabled source 3 still latches
    cyc(8'h00, 1'b1, 32'h0000_0800);
    cyc(8'h08, 1'b0, 32'h0);
    check("R3 latch while disabled", rd_data, 32'h0000_0808);
    check("R3 irq stays low", {31'd0, irq_out}, 32'd0);
    cyc(8'h00, 1'b1, 32'h0000_0000);
    check("R4 irq after enable", {31'd0, irq_out}, 32'd1);

    // R6: event and acknowledge on source 5 at the same edge
    cyc(8'h20, 1'b0, 32'h0);
    cyc(8'h20, 1'b1, 32'h0020_0000);
    check("R6 set wins over ack", rd_data, 32'h0000_0028);

    // R8: write to status and upper byte ignored
    cyc(8'h00, 1'b1, 32'hFF00_00FF);
    check("R8 ignored bits", rd_data, 32'h0000_0028);
    check("R8 upper half zero", {16'd0, rd_data[31:16]}, 32'h0);

    // R5: acknowledge of two sources leaves others
    cyc(8'h00, 1'b1, 32'h0028_0000);
    check("R5 ack two sources", rd_data, 32'h0000_0000);
    check("R4 irq low after ack", {31'd0, irq_out}, 32'd0);

    // random mix, compared every cycle by the model
    for (int k = 0; k < 2000; k++) begin
      logic [7:0]  e;
      logic        w;
      logic [31:0] d;
      e = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      w = ($urandom_range(0, 2) == 0);
      d = $urandom;
      cyc(e, w, d);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule